// File: doc/BRIEF.md
# Configurable SPI Master/Slave Transceiver

This block is a byte-wide synchronous serial port that one CPU controls through a small register bus. It can run as the bus master or as a slave. In both roles it moves one byte out and one byte in at the same time, through a single shift register, most significant bit first. Software chooses the idle level of the serial clock and which clock edge samples the data. In master mode it also chooses one of four serial clock rates.

As master, a write to the data register starts a transfer. The block then drives the serial clock and the outgoing data line, and it drives a register-held pattern onto eight active-low select outputs for the length of the byte. As slave, the block follows an external clock while its own select input is low. Its external inputs pass through two-stage synchronizers first.

The status register reports four conditions:
- a finished byte;
- a data write that arrived during a transfer (a write collision);
- a mode fault, raised when another device pulls the select input low while this block is master. The block then demotes itself to slave and turns its clock and data drivers off.
- the transfer-in-progress state.

Top module: `spi_xcvr`

Register map (2-bit address):
- 0, control: bit0 enable, bit1 master, bit2 clock idle level, bit3 clock phase, bits 5:4 rate code, bits 7:6 spare (read back as written).
- 1, status (read only): bit7 done, bit6 collision, bit4 mode fault, bit0 busy, all other bits 0.
- 2, data: a write loads the outgoing byte; a read returns the last byte received.
- 3, select pattern: the active-low value placed on the select outputs during master transfers.

## Requirements
- R1: After reset, the control and status registers read 0x00, the select outputs are all ones, and the sck_oe, mosi_oe and miso_oe enables are low.
- R2: In master mode, a data write while idle sends that byte on mosi_out and receives a byte from miso_in, both MSB first, in 16 clock edges. The received byte is readable at address 2. While idle, sck_out rests at the level of control bit2.
- R3: With control bit3 = 0, data is sampled on the leading clock edge (the edge that leaves the idle level), and the first bit is valid before that edge. With bit3 = 1, data changes on the leading edge and is sampled on the trailing edge. This holds in both master and slave roles.
- R4: In master mode, each sck half period lasts 2 << rate system clocks for rate codes 0 to 3, so the serial clock runs at CLK/4, CLK/8, CLK/16 or CLK/32.
- R5: Status bit7 sets at the end of each byte. It is cleared only by a status read that sees a flag set followed by an access to the data register. A data access with no such status read before it leaves the bit set.
- R6: A data write during a transfer sets status bit6 and has no effect on the byte in flight. Bit6 is cleared by the same sequence as bit7.
- R7: When the select input is low while the block is enabled as master, status bit4 sets, control bit1 clears, any transfer in progress stops without setting bit7, and sck_oe and mosi_oe go low.
- R8: After a mode fault, the clock and data drivers stay off until a status read that sees bit4 is followed by a control write. That control write clears bit4. A control write without that status read before it leaves bit4 set and the drivers off.
- R9: The select outputs carry the select register only while a master transfer is in progress, and they are all ones at every other time.
- R10: In slave mode, a byte is exchanged against an external clock on sck_in and mosi_in while ss_n_in is low. miso_oe is high only while the block is enabled as slave and selected.
- R11: Raising ss_n_in in the middle of a slave byte abandons that byte: busy clears and bit7 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; also triggers the flag-clear sequence |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock generated in master mode |
| sck_oe | output | 1 | Drive enable for sck_out |
| mosi_in | input | 1 | Serial data in, slave role |
| mosi_out | output | 1 | Serial data out, master role |
| mosi_oe | output | 1 | Drive enable for mosi_out |
| miso_in | input | 1 | Serial data in, master role |
| miso_out | output | 1 | Serial data out, slave role |
| miso_oe | output | 1 | Drive enable for miso_out |
| ss_n_in | input | 1 | Active-low select input (slave select / fault sense) |
| ss_n_out | output | SS_W | Active-low select outputs |

## Verification
The assertions check these properties on every cycle:
- the drivers stay off while a mode fault is pending;
- a fault always clears the master bit;
- the master clock rests at its idle level between bytes;
- the rate generator never produces two ticks in a row;
- a colliding write never ends a transfer;
- the select outputs return high after each byte;
- the first outgoing bit follows a load.

Only the directed scenarios can show the following:
- that the bytes arrive intact in all four clock modes;
- that the measured half periods match each rate code;
- the exact order of reads and writes that clears each flag;
- how a slave byte behaves when its select input is pulled away.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
    localparam int unsigned BYTE_W = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_SSEL = 2'd3;

    typedef struct packed {
        logic [1:0] spare;
        logic [1:0] rate;
        logic       cpha;
        logic       cpol;
        logic       mstr;
        logic       en;
    } ctrl_t;
endpackage

// File: rtl/spi_xcvr_sync.sv
module spi_xcvr_sync #(
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = d;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/spi_xcvr_rate.sv
module spi_xcvr_rate #(
    parameter int RATE_W   = 2,
    parameter int BASE_LOG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int MAX_LOG = BASE_LOG + (1 << RATE_W) - 1;
    localparam int CW      = MAX_LOG + 1;

    logic [CW-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = (CW'(1) << (BASE_LOG + int'(rate))) - CW'(1);
        tick  = run && (cnt_q == limit);
        cnt_d = (!run || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the fastest rate still leaves a gap between ticks (CLK/4)
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/spi_xcvr_shift.sv
module spi_xcvr_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         lead,
    input  logic         trail,
    input  logic         cpha,
    input  logic         din,
    input  logic         abort,
    output logic         dout,
    output logic         done,
    output logic [W-1:0] rx_data
);
    localparam int CNT_W = $clog2(W);

    typedef struct packed {
        logic [W-1:0]     sr;
        logic [W-1:0]     rx;
        logic [CNT_W-1:0] cnt;
        logic             smp;
        logic             out;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        done = 1'b0;
        if (abort) begin
            sh_d.cnt = '0;
        end else if (load) begin
            sh_d.sr  = load_data;
            sh_d.out = load_data[W-1];
            sh_d.cnt = '0;
        end else begin
            if (lead) begin
                if (!cpha) sh_d.smp = din;
                else       sh_d.out = sh_q.sr[W-1];
            end
            if (trail) begin
                sh_d.sr = {sh_q.sr[W-2:0], (cpha ? din : sh_q.smp)};
                if (!cpha) sh_d.out = sh_q.sr[W-2];
                if (sh_q.cnt == CNT_W'(W-1)) begin
                    done      = 1'b1;
                    sh_d.cnt  = '0;
                    sh_d.rx   = sh_d.sr;
                end else begin
                    sh_d.cnt = sh_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout    = sh_q.out;
    assign rx_data = sh_q.rx;

    // R2: a load presents the MSB on the serial output on the next cycle
    assert_load_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !abort) |=> (dout == $past(load_data[W-1])));
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int SS_W          = 8,
    parameter int RATE_BASE_LOG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              ss_n_in,
    output logic [SS_W-1:0]   ss_n_out
);
    typedef struct packed {
        ctrl_t           ctrl;
        logic [SS_W-1:0] ssel;
        logic            done;
        logic            wcol;
        logic            modf;
        logic            arm;
        logic            busy;
        logic            phase;
        logic            sck_prev;
    } st_t;

    st_t st_d, st_q;

    logic [2:0]        sync_q;
    logic              ss_s, sck_s, mosi_s;
    logic              is_master, is_slave, fault, sel_s;
    logic              wr_ctrl, wr_data, rd_data, rd_stat, wr_ssel;
    logic              run, tick, lead, trail, s_lead, s_trail, sck_chg;
    logic              load, abort, sh_done, sh_dout, sh_din;
    logic [BYTE_W-1:0] rx_byte;

    spi_xcvr_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_in, sck_in, mosi_in}),
        .q     (sync_q)
    );
    assign ss_s   = sync_q[2];
    assign sck_s  = sync_q[1];
    assign mosi_s = sync_q[0];

    spi_xcvr_rate #(.RATE_W(2), .BASE_LOG(RATE_BASE_LOG)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .rate  (st_q.ctrl.rate),
        .tick  (tick)
    );

    spi_xcvr_shift #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (bus_wdata),
        .lead      (lead),
        .trail     (trail),
        .cpha      (st_q.ctrl.cpha),
        .din       (sh_din),
        .abort     (abort),
        .dout      (sh_dout),
        .done      (sh_done),
        .rx_data   (rx_byte)
    );

    always_comb begin
        is_master = st_q.ctrl.en && st_q.ctrl.mstr;
        is_slave  = st_q.ctrl.en && !st_q.ctrl.mstr;
        fault     = is_master && !ss_s;
        sel_s     = is_slave && !ss_s;

        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_data = bus_wr && (bus_addr == A_DATA);
        wr_ssel = bus_wr && (bus_addr == A_SSEL);
        rd_data = bus_rd && (bus_addr == A_DATA);
        rd_stat = bus_rd && (bus_addr == A_STAT);

        run     = st_q.busy && is_master;
        sck_chg = sck_s != st_q.sck_prev;
        s_lead  = sel_s && sck_chg && (sck_s != st_q.ctrl.cpol);
        s_trail = sel_s && sck_chg && (sck_s == st_q.ctrl.cpol);
        lead    = is_master ? (tick && !st_q.phase) : s_lead;
        trail   = is_master ? (tick &&  st_q.phase) : s_trail;
        sh_din  = is_master ? miso_in : mosi_s;

        load  = wr_data && !st_q.busy;
        abort = fault ||
                (st_q.busy && (!st_q.ctrl.en || (!is_master && ss_s)));

        st_d          = st_q;
        st_d.sck_prev = sck_s;

        if (run && tick) st_d.phase = !st_q.phase;

        if (abort || sh_done) begin
            st_d.busy  = 1'b0;
            st_d.phase = 1'b0;
        end else if (load && is_master) begin
            st_d.busy  = 1'b1;
            st_d.phase = 1'b0;
        end else if (s_lead) begin
            st_d.busy  = 1'b1;
        end

        if (wr_ctrl) st_d.ctrl = ctrl_t'(bus_wdata);
        if (wr_ssel) st_d.ssel = SS_W'(bus_wdata);

        // second step of the clear sequences
        if ((wr_data || rd_data) && st_q.arm) begin
            st_d.done = 1'b0;
            st_d.wcol = 1'b0;
            st_d.arm  = 1'b0;
        end
        if (wr_ctrl && st_q.arm) begin
            st_d.modf = 1'b0;
            st_d.arm  = 1'b0;
        end
        // first step: a status read that sees a flag
        if (rd_stat && (st_q.done || st_q.wcol || st_q.modf)) st_d.arm = 1'b1;

        // new events win over clearing
        if (sh_done)              st_d.done = 1'b1;
        if (wr_data && st_q.busy) st_d.wcol = 1'b1;
        if (fault) begin
            st_d.modf      = 1'b1;
            st_d.ctrl.mstr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = st_q.ctrl;
            A_STAT:  bus_rdata = {st_q.done, st_q.wcol, 1'b0, st_q.modf,
                                  3'b000, st_q.busy};
            A_DATA:  bus_rdata = rx_byte;
            default: bus_rdata = BYTE_W'(st_q.ssel);
        endcase
    end

    assign sck_out  = st_q.ctrl.cpol ^ st_q.phase;
    assign sck_oe   = is_master && !st_q.modf;
    assign mosi_out = sh_dout;
    assign mosi_oe  = sck_oe;
    assign miso_out = sh_dout;
    assign miso_oe  = sel_s;
    assign ss_n_out = (st_q.busy && is_master) ? st_q.ssel : '1;

    // R7: a pending fault keeps both master drivers released
    assert_drv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.modf |-> (!sck_oe && !mosi_oe));

    // R7: a fault always demotes the block from master
    assert_fault_demote_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.modf) |-> !st_q.ctrl.mstr);

    // R2: an idle master clock rests at the programmed polarity
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !st_q.busy) |-> (sck_out == st_q.ctrl.cpol));

    // R6: a colliding write never ends the transfer in flight
    assert_wcol_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && st_q.busy && !abort && !sh_done) |=> st_q.busy);

    // R9: selects are released after every finished byte
    assert_ss_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |=> (ss_n_out == '1));
endmodule

// File: tb/spi_xcvr_tb.sv
`timescale 1ns/1ps
module spi_xcvr_tb;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_SSEL = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic sck_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;
    logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
    logic miso_tb = 1'b0, lb = 1'b0;
    logic miso_in;
    logic [7:0] ss_n_out;
    int total = 0, bad = 0;

    assign miso_in = lb ? mosi_out : miso_tb;

    always #4 clk = ~clk;

    spi_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ss_n_in(ss_n_in), .ss_n_out(ss_n_out)
    );

    task automatic check(input logic ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string what);
        logic [7:0] v;
        bus_read(a, v);
        check(v == exp, what, v, exp);
    endtask

    task automatic test_reset();
        expect_reg(A_CTRL, 8'h00, "R1 control after reset");
        expect_reg(A_STAT, 8'h00, "R1 status after reset");
        check(ss_n_out == 8'hFF, "R1 selects idle", ss_n_out, 8'hFF);
        check(!sck_oe && !mosi_oe, "R1 master drivers off", {sck_oe, mosi_oe}, 0);
        check(!miso_oe, "R1 slave driver off", miso_oe, 0);
    endtask

    task automatic master_xfer(input logic [7:0] dtx, input logic [7:0] ttx,
                               input logic cp, input logic ch, input logic [1:0] rt);
        logic [7:0] trx = '0;
        int edges = 0, k = 0, cyc = 0, last = 0, half = 0;
        logic prev;
        lb = 1'b0;
        bus_write(A_CTRL, {2'b00, rt, ch, cp, 2'b11});
        miso_tb = ttx[7];
        prev = sck_out;
        check(sck_out == cp, "R2 sck idle level before byte", sck_out, cp);
        bus_write(A_DATA, dtx);
        while (edges < 16 && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (sck_out !== prev) begin
                edges++;
                if (edges == 2) half = cyc - last;
                last = cyc;
                prev = sck_out;
                if (sck_out != cp) begin
                    if (!ch) trx = {trx[6:0], mosi_out};
                    else begin miso_tb = ttx[7-k]; k++; end
                end else begin
                    if (ch) trx = {trx[6:0], mosi_out};
                    else begin k++; if (k < 8) miso_tb = ttx[7-k]; end
                end
            end
        end
        repeat (4) @(negedge clk);
        check(edges == 16, "R2 sixteen clock edges", edges, 16);
        check(half == (2 << rt), "R4 half period", half, 2 << rt);
        check(trx == dtx, "R3 byte seen on mosi", trx, dtx);
        check(sck_out == cp, "R2 sck idle level after byte", sck_out, cp);
        expect_reg(A_STAT, 8'h80, "R5 done after master byte");
        expect_reg(A_DATA, ttx, "R2 byte received from miso");
        expect_reg(A_STAT, 8'h00, "R5 done cleared by sequence");
    endtask

    task automatic test_master_modes();
        for (int i = 0; i < 4; i++)
            master_xfer(8'hA5 ^ 8'(i * 37), 8'h3C + 8'(i * 29), 1'(i % 2), 1'(i / 2), 2'(i));
    endtask

    task automatic test_done_clear();
        logic [7:0] v;
        lb = 1'b1;
        bus_write(A_CTRL, 8'h03);
        bus_write(A_DATA, 8'h96);
        repeat (80) @(negedge clk);
        bus_read(A_DATA, v);
        check(v == 8'h96, "R2 loopback byte", v, 8'h96);
        expect_reg(A_STAT, 8'h80, "R5 data read alone keeps done");
        bus_read(A_DATA, v);
        expect_reg(A_STAT, 8'h00, "R5 status then data clears done");
    endtask

    task automatic test_wcol();
        lb = 1'b1;
        bus_write(A_CTRL, 8'h33);
        bus_write(A_DATA, 8'hA5);
        repeat (40) @(negedge clk);
        bus_write(A_DATA, 8'h3C);
        expect_reg(A_STAT, 8'h41, "R6 collision flagged, still busy");
        repeat (600) @(negedge clk);
        expect_reg(A_STAT, 8'hC0, "R6 byte finished after collision");
        expect_reg(A_DATA, 8'hA5, "R6 byte in flight unaffected");
        expect_reg(A_STAT, 8'h00, "R6 collision cleared by sequence");
    endtask

    task automatic test_ssel();
        logic [7:0] v;
        lb = 1'b1;
        bus_write(A_CTRL, 8'h03);
        bus_write(A_SSEL, 8'hA6);
        check(ss_n_out == 8'hFF, "R9 selects idle before byte", ss_n_out, 8'hFF);
        bus_write(A_DATA, 8'h5A);
        repeat (4) @(negedge clk);
        check(ss_n_out == 8'hA6, "R9 selects driven in byte", ss_n_out, 8'hA6);
        repeat (60) @(negedge clk);
        check(ss_n_out == 8'hFF, "R9 selects released after byte", ss_n_out, 8'hFF);
        expect_reg(A_STAT, 8'h80, "R5 done after select test");
        bus_read(A_DATA, v);
        check(v == 8'h5A, "R2 loopback byte with selects", v, 8'h5A);
    endtask

    task automatic slave_xfer(input logic [7:0] dtx, input logic [7:0] ttx,
                              input logic cp, input logic ch);
        logic [7:0] trx = '0;
        lb = 1'b0;
        ss_n_in = 1'b1; sck_in = cp; mosi_in = 1'b0;
        repeat (4) @(negedge clk);
        bus_write(A_CTRL, {4'b0000, ch, cp, 2'b01});
        bus_write(A_DATA, dtx);
        check(!miso_oe, "R10 miso off while deselected", miso_oe, 0);
        ss_n_in = 1'b0;
        repeat (8) @(negedge clk);
        check(miso_oe, "R10 miso on while selected", miso_oe, 1);
        for (int b = 7; b >= 0; b--) begin
            if (!ch) begin
                mosi_in = ttx[b];
                repeat (4) @(negedge clk);
                trx = {trx[6:0], miso_out};
                sck_in = ~cp;
                repeat (8) @(negedge clk);
                sck_in = cp;
                repeat (4) @(negedge clk);
            end else begin
                sck_in = ~cp; mosi_in = ttx[b];
                repeat (8) @(negedge clk);
                trx = {trx[6:0], miso_out};
                sck_in = cp;
                repeat (8) @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
        ss_n_in = 1'b1;
        repeat (6) @(negedge clk);
        check(trx == dtx, "R10 slave byte on miso", trx, dtx);
        expect_reg(A_STAT, 8'h80, "R10 slave done");
        expect_reg(A_DATA, ttx, "R3 slave received byte");
        expect_reg(A_STAT, 8'h00, "R5 slave done cleared");
    endtask

    task automatic test_slave();
        slave_xfer(8'hC3, 8'h1E, 1'b0, 1'b0);
        slave_xfer(8'h6D, 8'hB2, 1'b1, 1'b1);
    endtask

    task automatic test_slave_abort();
        lb = 1'b0;
        sck_in = 1'b0; ss_n_in = 1'b1;
        bus_write(A_CTRL, 8'h01);
        bus_write(A_DATA, 8'hF0);
        ss_n_in = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 0; b < 3; b++) begin
            mosi_in = 1'(b);
            repeat (4) @(negedge clk);
            sck_in = 1'b1;
            repeat (8) @(negedge clk);
            sck_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        expect_reg(A_STAT, 8'h01, "R11 busy mid slave byte");
        ss_n_in = 1'b1;
        repeat (8) @(negedge clk);
        expect_reg(A_STAT, 8'h00, "R11 slave byte abandoned");
    endtask

    task automatic test_modf();
        lb = 1'b1;
        ss_n_in = 1'b1;
        bus_write(A_CTRL, 8'h33);
        bus_write(A_DATA, 8'h77);
        repeat (10) @(negedge clk);
        check(sck_oe && mosi_oe, "R7 drivers on before fault", {sck_oe, mosi_oe}, 3);
        ss_n_in = 1'b0;
        repeat (6) @(negedge clk);
        check(!sck_oe && !mosi_oe, "R7 drivers off on fault", {sck_oe, mosi_oe}, 0);
        expect_reg(A_CTRL, 8'h31, "R7 master bit cleared");
        ss_n_in = 1'b1;
        repeat (6) @(negedge clk);
        bus_write(A_CTRL, 8'h33);
        repeat (2) @(negedge clk);
        check(!sck_oe, "R8 control write alone keeps drivers off", sck_oe, 0);
        expect_reg(A_STAT, 8'h10, "R7 fault flag, transfer stopped");
        bus_write(A_CTRL, 8'h33);
        repeat (2) @(negedge clk);
        check(sck_oe && mosi_oe, "R8 drivers back after sequence", {sck_oe, mosi_oe}, 3);
        expect_reg(A_STAT, 8'h00, "R8 fault flag cleared");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_master_modes();
        test_done_clear();
        test_wcol();
        test_ssel();
        test_slave();
        test_slave_abort();
        test_modf();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule